// File: doc/BRIEF.md
# Flash Page Hamming Parity Generator

This block computes a single-error-correcting Hamming parity over one 256-byte slice of a flash page's data area. Bytes arrive one per cycle with a strobe. A byte counts only while the ECC enable input is high. For each byte the block accumulates two kinds of parity. Column parity covers groups of bit positions inside the byte. Line parity covers groups of byte positions within the slice.

After the last byte of a slice is accepted, the block does four things:

- It latches the raw parity word.
- It latches the 24-bit code in the form written to the spare area.
- It pulses a completion strobe.
- It plays the code out as three bytes, most significant byte first.

The accumulator then restarts on its own for the next slice. A clear input throws away a partial slice so that a new transfer starts from a known state. Spare-area bytes are kept out of the parity by holding the enable low while they pass.

Top module: `ecc_page_hamming_gen`

## Requirements
- R1: While reset is held, and after its release until the first slice completes, `code_valid` and `code_byte_valid` are 0 and both `raw_parity` and `code_word` are 0.
- R2: A byte is accepted only in a cycle where `byte_valid` and `ecc_en` are both 1. A byte offered with `ecc_en` at 0, or a cycle with `byte_valid` at 0, changes neither the parity nor the byte count.
- R3: `code_valid` is high for exactly one cycle: the cycle after the clock edge that accepts the 256th byte of a slice. It is low at all other times.
- R4: Bits [5:0] of `raw_parity` hold the column parity. For group j (0 to 2), bit 2j is the XOR of all data bits at positions whose bit j is 0. Bit 2j+1 is the XOR of all data bits at positions whose bit j is 1. Both are taken over every accepted byte of the slice.
- R5: Bits [21:6] of `raw_parity` hold the line parity. Each byte's index is its acceptance order within the slice, 0 to 255. For index bit k (0 to 7), bit 6+2k is the XOR of the byte parities of all bytes whose index bit k is 0. Bit 7+2k is the same XOR over the bytes whose index bit k is 1.
- R6: `code_word` equals the bitwise inverse of `raw_parity` shifted left by two, kept to 24 bits. Its two low bits are therefore always 1.
- R7: On the three cycles after the `code_valid` cycle, `code_byte_valid` is 1. `code_byte` carries `code_word[23:16]`, then `[15:8]`, then `[7:0]`. Afterwards `code_byte_valid` returns to 0.
- R8: `ecc_clear` empties the partial parity and resets the byte count. A byte offered in the same cycle as `ecc_clear` is not accepted. The next accepted byte has index 0.
- R9: A new slice may begin on the cycle right after a completed one, with no idle cycle between them. `raw_parity` and `code_word` hold their latched values until the next slice completes.
- R10: A slice of 256 bytes of 0xFF yields `raw_parity` = 0 and `code_word` = 0xFFFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ecc_clear | input | 1 | Discard the partial slice and restart counting |
| ecc_en | input | 1 | Bytes count only while high |
| byte_valid | input | 1 | Byte strobe |
| byte_data | input | 8 | Data byte |
| raw_parity | output | 22 | Latched raw parity: line parity over column parity |
| code_word | output | 24 | Latched stored-form code |
| code_valid | output | 1 | One-cycle pulse when a slice completes |
| code_byte | output | 8 | Code byte stream, most significant byte first |
| code_byte_valid | output | 1 | Qualifies `code_byte` |

## Verification
The hardest conditions to reach are the edges of the byte count. Three cases matter. A clear can arrive together with a valid byte in the middle of a slice. A second slice can start on the very cycle the first one completes. Bytes can be strobed while the enable is low. Each of these only shows up as an off-by-one in when the completion pulse fires, or as a wrong parity bit. The stimulus reaches them with directed streams. One stream interleaves disabled and idle beats between real bytes. Another stops after 100 bytes and clears with a byte present. A third streams 512 bytes with no gap while checking the pulse and the held result mid-stream. In every case the expected parity comes from a bench model of the line and column groups.

// File: rtl/ecc_hamming_pkg.sv
package ecc_hamming_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/ecc_col_parity.sv
module ecc_col_parity #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CB    = $clog2(DATA_W),
  localparam int unsigned COL_W = 2 * CB
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [COL_W-1:0]  col_o,
  output logic              par_o
);
  function automatic logic [DATA_W-1:0] hi_mask(input int j);
    logic [DATA_W-1:0] m;
    for (int b = 0; b < DATA_W; b++) m[b] = ((b >> j) & 1) == 1;
    return m;
  endfunction

  for (genvar j = 0; j < CB; j++) begin : g_grp
    localparam logic [DATA_W-1:0] HI = hi_mask(j);
    assign col_o[2*j]   = ^(data_i & ~HI);
    assign col_o[2*j+1] = ^(data_i &  HI);
  end

  assign par_o = ^data_i;
endmodule

// File: rtl/ecc_line_accum.sv
module ecc_line_accum #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned BLOCK_BYTES = 256,
  localparam int unsigned IDX_W  = $clog2(BLOCK_BYTES),
  localparam int unsigned COL_W  = 2 * $clog2(DATA_W),
  localparam int unsigned LINE_W = 2 * IDX_W,
  localparam int unsigned RAW_W  = LINE_W + COL_W,
  localparam int unsigned CODE_W = RAW_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              accept,
  input  logic [COL_W-1:0]  col_in,
  input  logic              par_in,
  output logic [RAW_W-1:0]  raw_q,
  output logic [CODE_W-1:0] code_q,
  output logic              done_q
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLOCK_BYTES - 1);

  logic [IDX_W-1:0]  idx_q;
  logic [LINE_W-1:0] line_q, line_nxt;
  logic [COL_W-1:0]  col_q, col_nxt;
  logic [RAW_W-1:0]  raw_nxt;
  logic              last_beat;

  for (genvar k = 0; k < IDX_W; k++) begin : g_line
    assign line_nxt[2*k]   = line_q[2*k]   ^ (par_in & ~idx_q[k]);
    assign line_nxt[2*k+1] = line_q[2*k+1] ^ (par_in &  idx_q[k]);
  end

  assign col_nxt   = col_q ^ col_in;
  assign raw_nxt   = {line_nxt, col_nxt};
  assign last_beat = accept && (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      line_q <= '0;
      col_q  <= '0;
      raw_q  <= '0;
      code_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (clear) begin
        idx_q  <= '0;
        line_q <= '0;
        col_q  <= '0;
      end else if (last_beat) begin
        raw_q  <= raw_nxt;
        code_q <= ~{raw_nxt, 2'b00};
        done_q <= 1'b1;
        idx_q  <= '0;
        line_q <= '0;
        col_q  <= '0;
      end else if (accept) begin
        idx_q  <= idx_q + IDX_W'(1);
        line_q <= line_nxt;
        col_q  <= col_nxt;
      end
    end
  end

  // R3: completion is a single-cycle pulse
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  // R8: a clear never lets a slice complete on the next edge
  a_r8_clear_no_done: assert property (@(posedge clk) disable iff (rst)
    clear |=> !done_q);
  // R2: without an accepted byte the running state is frozen
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!accept && !clear) |=> ($stable(idx_q) && $stable(line_q) && $stable(col_q)));
  // R9: latched result only moves on completion
  a_r9_result_hold: assert property (@(posedge clk) disable iff (rst)
    !done_q |-> ($stable(raw_q) && $stable(code_q)));
endmodule

// File: rtl/ecc_code_serializer.sv
module ecc_code_serializer #(
  parameter int unsigned CODE_W = 24,
  localparam int unsigned NB    = (CODE_W + 7) / 8,
  localparam int unsigned SER_W = NB * 8,
  localparam int unsigned CNT_W = $clog2(NB + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CODE_W-1:0] code_i,
  output logic [7:0]        byte_o,
  output logic              byte_vld
);
  logic [SER_W-1:0] ser_word;
  logic [SER_W-1:0] sh_q;
  logic [CNT_W-1:0] left_q;

  assign ser_word = SER_W'(code_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q     <= '0;
      left_q   <= '0;
      byte_o   <= '0;
      byte_vld <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      if (load) begin
        byte_o   <= ser_word[SER_W-1 -: 8];
        sh_q     <= ser_word << 8;
        left_q   <= CNT_W'(NB - 1);
        byte_vld <= 1'b1;
      end else if (left_q != '0) begin
        byte_o   <= sh_q[SER_W-1 -: 8];
        sh_q     <= sh_q << 8;
        left_q   <= left_q - CNT_W'(1);
        byte_vld <= 1'b1;
      end
    end
  end

  // R7: a load starts the byte burst on the next cycle
  a_r7_burst_follows: assert property (@(posedge clk) disable iff (rst)
    load |=> byte_vld);
  // R7: a burst never begins without a load
  a_r7_no_orphan: assert property (@(posedge clk) disable iff (rst)
    $rose(byte_vld) |-> $past(load));
endmodule

// File: rtl/ecc_page_hamming_gen.sv
module ecc_page_hamming_gen
  import ecc_hamming_pkg::*;
#(
  parameter int unsigned DATA_W      = BYTE_W,
  parameter int unsigned BLOCK_BYTES = 256,
  localparam int unsigned COL_W  = 2 * $clog2(DATA_W),
  localparam int unsigned RAW_W  = 2 * $clog2(BLOCK_BYTES) + COL_W,
  localparam int unsigned CODE_W = RAW_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ecc_clear,
  input  logic              ecc_en,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  output logic [RAW_W-1:0]  raw_parity,
  output logic [CODE_W-1:0] code_word,
  output logic              code_valid,
  output byte_t             code_byte,
  output logic              code_byte_valid
);
  logic [COL_W-1:0] col_bits;
  logic             byte_par;
  logic             accept;

  assign accept = byte_valid & ecc_en;

  ecc_col_parity #(.DATA_W(DATA_W)) i_col (
    .data_i (byte_data),
    .col_o  (col_bits),
    .par_o  (byte_par)
  );

  ecc_line_accum #(.DATA_W(DATA_W), .BLOCK_BYTES(BLOCK_BYTES)) i_acc (
    .clk    (clk),
    .rst    (rst),
    .clear  (ecc_clear),
    .accept (accept),
    .col_in (col_bits),
    .par_in (byte_par),
    .raw_q  (raw_parity),
    .code_q (code_word),
    .done_q (code_valid)
  );

  ecc_code_serializer #(.CODE_W(CODE_W)) i_ser (
    .clk      (clk),
    .rst      (rst),
    .load     (code_valid),
    .code_i   (code_word),
    .byte_o   (code_byte),
    .byte_vld (code_byte_valid)
  );

  // R10: an all-zero parity must present an all-ones code
  a_r10_erased_code: assert property (@(posedge clk) disable iff (rst)
    (code_valid && raw_parity == '0) |-> (&code_word));
  // R3: the completion pulse and the byte burst never overlap
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (rst)
    code_valid |-> !code_byte_valid);
endmodule

// File: tb/test_ecc_page_hamming_gen.sv
`timescale 1ns/1ps
module test_ecc_page_hamming_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ecc_clear = 1'b0;
  logic        ecc_en = 1'b0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_data = 8'h00;
  logic [21:0] raw_parity;
  logic [23:0] code_word;
  logic        code_valid;
  logic [7:0]  code_byte;
  logic        code_byte_valid;

  int n_chk = 0;
  int n_bad = 0;
  int pulses = 0;

  logic [7:0] blk_a [256];
  logic [7:0] blk_b [256];

  always #2 clk = ~clk;

  ecc_page_hamming_gen i_ecc_page_hamming_gen (
    .clk(clk), .rst(rst), .ecc_clear(ecc_clear), .ecc_en(ecc_en),
    .byte_valid(byte_valid), .byte_data(byte_data),
    .raw_parity(raw_parity), .code_word(code_word), .code_valid(code_valid),
    .code_byte(code_byte), .code_byte_valid(code_byte_valid)
  );

  always @(posedge clk) if (code_valid === 1'b1) pulses++;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [21:0] ref_raw(input logic [7:0] a [256]);
    logic [15:0] ln = '0;
    logic [5:0]  cl = '0;
    for (int i = 0; i < 256; i++) begin
      logic p = ^a[i];
      for (int k = 0; k < 8; k++)
        if ((i >> k) & 1) ln[2*k+1] ^= p; else ln[2*k] ^= p;
      for (int j = 0; j < 3; j++)
        for (int b = 0; b < 8; b++)
          if ((b >> j) & 1) cl[2*j+1] ^= a[i][b]; else cl[2*j] ^= a[i][b];
    end
    return {ln, cl};
  endfunction

  task automatic beat(input bit v, input bit en, input bit clr, input logic [7:0] d);
    @(negedge clk);
    byte_valid = v; ecc_en = en; ecc_clear = clr; byte_data = d;
  endtask

  task automatic feed(input logic [7:0] a [256], input bit gaps);
    for (int i = 0; i < 256; i++) begin
      if (gaps && (i % 3 == 0)) beat(1, 0, 0, ~a[i]);
      if (gaps && (i % 5 == 0)) beat(0, 1, 0, 8'hA5);
      beat(1, 1, 0, a[i]);
    end
  endtask

  task automatic check_out(input string tag, input logic [21:0] exp);
    logic [23:0] ec = ~{exp, 2'b00};
    beat(0, 1, 0, 8'h00);
    check({tag, " R3 pulse"}, 32'(code_valid), 32'd1);
    check({tag, " R4 R5 raw"}, 32'(raw_parity), 32'(exp));
    check({tag, " R6 code"}, 32'(code_word), 32'(ec));
    check({tag, " R3 no-burst-yet"}, 32'(code_byte_valid), 32'd0);
    beat(0, 1, 0, 8'h00);
    check({tag, " R3 pulse end"}, 32'(code_valid), 32'd0);
    check({tag, " R7 b0"}, {23'd0, code_byte_valid, code_byte}, {23'd0, 1'b1, ec[23:16]});
    beat(0, 1, 0, 8'h00);
    check({tag, " R7 b1"}, {23'd0, code_byte_valid, code_byte}, {23'd0, 1'b1, ec[15:8]});
    beat(0, 1, 0, 8'h00);
    check({tag, " R7 b2"}, {23'd0, code_byte_valid, code_byte}, {23'd0, 1'b1, ec[7:0]});
    beat(0, 1, 0, 8'h00);
    check({tag, " R7 end"}, 32'(code_byte_valid), 32'd0);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 valid", {30'd0, code_valid, code_byte_valid}, 32'd0);
    check("R1 raw", 32'(raw_parity), 32'd0);
    check("R1 code", 32'(code_word), 32'd0);
    rst = 1'b0;
    beat(0, 1, 0, 8'h00);
    check("R1 after release", {8'd0, code_word}, 32'd0);
  endtask

  task automatic t_erased;
    for (int i = 0; i < 256; i++) blk_a[i] = 8'hFF;
    feed(blk_a, 0);
    check_out("R10 erased", 22'd0);
    check("R10 code ones", 32'(code_word), 32'h00FF_FFFF);
  endtask

  task automatic t_single_bit;
    for (int i = 0; i < 256; i++) blk_a[i] = 8'h00;
    blk_a[8'h5A] = 8'h10;
    feed(blk_a, 0);
    check_out("R4 R5 single", ref_raw(blk_a));
  endtask

  task automatic t_pattern;
    for (int i = 0; i < 256; i++) blk_a[i] = 8'(i * 37 + 11);
    feed(blk_a, 0);
    check_out("R5 pattern", ref_raw(blk_a));
  endtask

  task automatic t_gaps;
    for (int i = 0; i < 256; i++) blk_a[i] = 8'((i << 1) ^ (i >> 3) ^ 8'h5C);
    feed(blk_a, 1);
    check_out("R2 gaps", ref_raw(blk_a));
  endtask

  task automatic t_clear;
    int p0;
    for (int i = 0; i < 256; i++) blk_b[i] = 8'(i ^ 8'hC3);
    p0 = pulses;
    for (int i = 0; i < 100; i++) beat(1, 1, 0, 8'h37);
    beat(1, 1, 1, 8'h01);
    feed(blk_b, 0);
    check_out("R8 clear", ref_raw(blk_b));
    beat(0, 1, 0, 8'h00);
    check("R8 one pulse", 32'(pulses - p0), 32'd1);
  endtask

  task automatic t_back_to_back;
    int p0;
    for (int i = 0; i < 256; i++) begin
      blk_a[i] = 8'(i * 5 + 3);
      blk_b[i] = 8'(~(i * 11));
    end
    p0 = pulses;
    for (int i = 0; i < 256; i++) beat(1, 1, 0, blk_a[i]);
    for (int i = 0; i < 256; i++) begin
      beat(1, 1, 0, blk_b[i]);
      if (i == 0) begin
        check("R9 first pulse", 32'(code_valid), 32'd1);
        check("R9 first raw", 32'(raw_parity), 32'(ref_raw(blk_a)));
      end
      if (i == 1) check("R3 pulse once", 32'(code_valid), 32'd0);
      if (i == 100) check("R9 hold", 32'(raw_parity), 32'(ref_raw(blk_a)));
    end
    check_out("R9 second", ref_raw(blk_b));
    beat(0, 1, 0, 8'h00);
    check("R9 two pulses", 32'(pulses - p0), 32'd2);
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    n_bad++;
    $display("FAIL R3 watchdog act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_erased();
    t_single_bit();
    t_pattern();
    t_gaps();
    t_clear();
    t_back_to_back();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule